// File: doc/BRIEF.md
# Hash Engine Status and Access Monitor

This unit gathers the status of a hash accelerator into one read-only 32-bit word and raises an interrupt line. It takes three kinds of input from the hash core:

- a pulse when a message block has been digested;
- a pulse when a digest comparison has finished, carrying a 4-bit compare code;
- a level that says whether the first input data register can be written.

Software-side control pulses clear the completion fields: start, software reset and result read.

The unit also watches for illegal register accesses. These arrive as already-decoded strobes, one per kind. The unit qualifies them with the current busy, DMA and dual-buffer flags. It then keeps a sticky detection flag together with the code of the most recent offending kind. Only a software reset clears the flag and the code.

The status word is built from registered flags and the live write-ready level. The interrupt is the OR of the three sticky conditions, each gated by its own enable input.

Top module: `hash_status_mon`

## Requirements
- R1: While reset is held and after its release, before any event, status_o is all zeros with in_ready_i low, and irq_o is low.
- R2: Field positions in status_o are:
  - bit 0: data-ready
  - bit 4: write-ready
  - bit 8: access-detected
  - bits 14:12: access-type code
  - bit 16: check-done
  - bits 23:20: compare code
  
  Every other bit reads as zero.
- R3: Data-ready rises one clock after blk_done_i. It falls one clock after start_i, sw_rst_i or res_rd_i. When a set and a clear come in the same cycle, the set wins.
- R4: Check-done rises and chk_code_i is captured one clock after chk_done_i. Both fall to zero one clock after start_i, sw_rst_i or res_rd_i. A set in the same cycle as a clear wins and loads the new code.
- R5: The compare code is passed through unchanged. Value 5 reports a matching digest and any other value reports a mismatch.
- R6: Illegal-access kinds are qualified as follows. Each qualified event records its code one clock later and sets access-detected.
  - Code 0: input write, counted only while busy_i and dma_mode_i are both high.
  - Code 1: output read, counted only while busy_i is high.
  - Code 2: mode write, counted only while busy_i is high.
  - Code 3: write-only read, counted at any time.
- R7: An input-write event while dual_buf_i is high has no effect on the access-type field or the access-detected flag.
- R8: The access-type field holds only the latest qualified event. When several qualified events share a cycle, the highest code is recorded.
- R9: Access-detected and the access-type field are cleared only by sw_rst_i. start_i and res_rd_i leave them unchanged. A qualified event in the same cycle as sw_rst_i wins.
- R10: Write-ready (bit 4) follows in_ready_i in the same cycle, without a register.
- R11: irq_o is the OR of three terms: data-ready AND irq_en_drdy_i, check-done AND irq_en_chk_i, and access-detected AND irq_en_acc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| blk_done_i | input | 1 | Block digest finished pulse |
| chk_done_i | input | 1 | Digest compare finished pulse |
| chk_code_i | input | 4 | Compare code valid with chk_done_i |
| in_ready_i | input | 1 | First input data register writable |
| start_i | input | 1 | Start command pulse |
| sw_rst_i | input | 1 | Software reset pulse |
| res_rd_i | input | 1 | Result data read pulse |
| acc_in_wr_i | input | 1 | Input data register written (kind 0 strobe) |
| acc_out_rd_i | input | 1 | Output data read (kind 1 strobe) |
| acc_mode_wr_i | input | 1 | Mode register written (kind 2 strobe) |
| acc_wo_rd_i | input | 1 | Write-only register read (kind 3 strobe) |
| busy_i | input | 1 | Hash core is processing |
| dma_mode_i | input | 1 | Data is fed by DMA |
| dual_buf_i | input | 1 | Dual input buffering enabled |
| irq_en_drdy_i | input | 1 | Interrupt enable for data-ready |
| irq_en_chk_i | input | 1 | Interrupt enable for check-done |
| irq_en_acc_i | input | 1 | Interrupt enable for access-detected |
| status_o | output | 32 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the cycles in which a setting event and a clearing pulse coincide on a field that already holds a value. Examples are a qualified access landing on a software reset while an older code is held, or a new compare code arriving together with a result read. A plain directed sequence rarely lines these up. The bench therefore sweeps all 4096 combinations of the twelve event and mode inputs twice, in two different orders, so that each combination meets many different prior states. A cycle-level model in the bench tracks the expected value of every field.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  localparam int STATUS_W = 32;
  localparam int CODE_W   = 4;
  localparam int TYPE_W   = 3;
  localparam int N_KIND   = 4;

  localparam int POS_DRDY = 0;
  localparam int POS_WRDY = 4;
  localparam int POS_ACC  = 8;
  localparam int POS_TYPE = 12;
  localparam int POS_CHK  = 16;
  localparam int POS_CODE = 20;

  typedef enum logic [TYPE_W-1:0] {
    KIND_IN_WR   = 3'd0,
    KIND_OUT_RD  = 3'd1,
    KIND_MODE_WR = 3'd2,
    KIND_WO_RD   = 3'd3
  } acc_kind_e;
endpackage

// File: rtl/hsm_event_flag.sv
module hsm_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_q));
endmodule

// File: rtl/hsm_compare_hold.sv
module hsm_compare_hold #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              clr_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  always_comb begin
    code_en = ld_i | clr_i;
    code_d  = ld_i ? code_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;

  assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (code_q == $past(code_i)));
  assert_code_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !ld_i) |=> (code_q == '0));
endmodule

// File: rtl/hsm_access_mon.sv
module hsm_access_mon
  import hsm_pkg::*;
#(
  parameter int NK = N_KIND,
  parameter int TW = TYPE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NK-1:0] strobe_i,
  input  logic          busy_i,
  input  logic          dma_mode_i,
  input  logic          dual_buf_i,
  input  logic          sw_rst_i,
  output logic          flag_o,
  output logic [TW-1:0] type_o
);
  logic [NK-1:0] qual;
  logic          any_ev;
  logic [TW-1:0] sel_code;
  logic          flag_q, flag_d, flag_en;
  logic [TW-1:0] type_q, type_d;

  generate
    for (genvar k = 0; k < NK; k++) begin : g_qual
      if (k == int'(KIND_IN_WR)) begin : g_in
        assign qual[k] = strobe_i[k] & busy_i & dma_mode_i & ~dual_buf_i;
      end else if (k == int'(KIND_WO_RD)) begin : g_any
        assign qual[k] = strobe_i[k];
      end else begin : g_busy
        assign qual[k] = strobe_i[k] & busy_i;
      end
    end
  endgenerate

  always_comb begin
    sel_code = '0;
    for (int k = 0; k < NK; k++) begin
      if (qual[k]) sel_code = TW'(k);
    end
    any_ev  = |qual;
    flag_en = any_ev | sw_rst_i;
    flag_d  = any_ev;
    type_d  = any_ev ? sel_code : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      type_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
      type_q <= type_d;
    end
  end

  assign flag_o = flag_q;
  assign type_o = type_q;

  assert_type_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    type_q < TW'(NK));
  assert_type_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q |-> (type_q == '0));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !sw_rst_i) |=> flag_q);
  assert_dual_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_buf_i && !sw_rst_i && (strobe_i[NK-1:1] == '0)) |=> ($stable(type_q) && $stable(flag_q)));
  assert_wo_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i[NK-1] |=> (type_q == TW'(NK-1)));
endmodule

// File: rtl/hash_status_mon.sv
module hash_status_mon
  import hsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_done_i,
  input  logic              chk_done_i,
  input  logic [CODE_W-1:0] chk_code_i,
  input  logic              in_ready_i,
  input  logic              start_i,
  input  logic              sw_rst_i,
  input  logic              res_rd_i,
  input  logic              acc_in_wr_i,
  input  logic              acc_out_rd_i,
  input  logic              acc_mode_wr_i,
  input  logic              acc_wo_rd_i,
  input  logic              busy_i,
  input  logic              dma_mode_i,
  input  logic              dual_buf_i,
  input  logic              irq_en_drdy_i,
  input  logic              irq_en_chk_i,
  input  logic              irq_en_acc_i,
  output logic [STATUS_W-1:0] status_o,
  output logic              irq_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              clr_done;
  logic              drdy, chk, acc;
  logic [CODE_W-1:0] code;
  logic [TYPE_W-1:0] acc_type;
  logic [N_KIND-1:0] strobes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign clr_done = start_i | sw_rst_i | res_rd_i;
  assign strobes  = {acc_wo_rd_i, acc_mode_wr_i, acc_out_rd_i, acc_in_wr_i};

  hsm_event_flag u_drdy (
    .clk(clk), .rst_n(rst_int_n), .set_i(blk_done_i), .clr_i(clr_done), .flag_o(drdy)
  );

  hsm_event_flag u_chk (
    .clk(clk), .rst_n(rst_int_n), .set_i(chk_done_i), .clr_i(clr_done), .flag_o(chk)
  );

  hsm_compare_hold #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_int_n), .ld_i(chk_done_i), .code_i(chk_code_i),
    .clr_i(clr_done), .code_o(code)
  );

  hsm_access_mon #(.NK(N_KIND), .TW(TYPE_W)) u_acc (
    .clk(clk), .rst_n(rst_int_n), .strobe_i(strobes), .busy_i(busy_i),
    .dma_mode_i(dma_mode_i), .dual_buf_i(dual_buf_i), .sw_rst_i(sw_rst_i),
    .flag_o(acc), .type_o(acc_type)
  );

  always_comb begin
    status_o                        = '0;
    status_o[POS_DRDY]              = drdy;
    status_o[POS_WRDY]              = in_ready_i;
    status_o[POS_ACC]               = acc;
    status_o[POS_TYPE +: TYPE_W]    = acc_type;
    status_o[POS_CHK]               = chk;
    status_o[POS_CODE +: CODE_W]    = code;
  end

  assign irq_o = (drdy & irq_en_drdy_i) | (chk & irq_en_chk_i) | (acc & irq_en_acc_i);

  assert_code_only_when_done_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !chk |-> (code == '0));
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (drdy || chk || acc));
  assert_start_keeps_acc_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc && (start_i || res_rd_i) && !sw_rst_i) |=> acc);
endmodule

// File: tb/sim_hash_status_mon.sv
`timescale 1ns/1ps
module sim_hash_status_mon;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_done_i = 0, chk_done_i = 0, in_ready_i = 0, start_i = 0, sw_rst_i = 0, res_rd_i = 0;
  logic [3:0] chk_code_i = 0;
  logic acc_in_wr_i = 0, acc_out_rd_i = 0, acc_mode_wr_i = 0, acc_wo_rd_i = 0;
  logic busy_i = 0, dma_mode_i = 0, dual_buf_i = 0;
  logic irq_en_drdy_i = 0, irq_en_chk_i = 0, irq_en_acc_i = 0;
  logic [31:0] status_o;
  logic irq_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  logic m_drdy = 0, m_chk = 0, m_acc = 0;
  logic [3:0] m_code = 0;
  logic [2:0] m_type = 0;

  always #2.5 clk = ~clk;

  hash_status_mon u0 (
    .clk(clk), .rst_n(rst_n), .blk_done_i(blk_done_i), .chk_done_i(chk_done_i),
    .chk_code_i(chk_code_i), .in_ready_i(in_ready_i), .start_i(start_i),
    .sw_rst_i(sw_rst_i), .res_rd_i(res_rd_i), .acc_in_wr_i(acc_in_wr_i),
    .acc_out_rd_i(acc_out_rd_i), .acc_mode_wr_i(acc_mode_wr_i), .acc_wo_rd_i(acc_wo_rd_i),
    .busy_i(busy_i), .dma_mode_i(dma_mode_i), .dual_buf_i(dual_buf_i),
    .irq_en_drdy_i(irq_en_drdy_i), .irq_en_chk_i(irq_en_chk_i), .irq_en_acc_i(irq_en_acc_i),
    .status_o(status_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = '0;
    s[0] = m_drdy; s[4] = in_ready_i; s[8] = m_acc;
    s[14:12] = m_type; s[16] = m_chk; s[23:20] = m_code;
    return s;
  endfunction

  function automatic logic exp_irq();
    return (m_drdy & irq_en_drdy_i) | (m_chk & irq_en_chk_i) | (m_acc & irq_en_acc_i);
  endfunction

  task automatic model_step();
    logic clr, v0, v1, v2, v3;
    clr = start_i | sw_rst_i | res_rd_i;
    if (blk_done_i) m_drdy = 1; else if (clr) m_drdy = 0;
    if (chk_done_i) begin m_chk = 1; m_code = chk_code_i; end
    else if (clr) begin m_chk = 0; m_code = 0; end
    v0 = acc_in_wr_i & busy_i & dma_mode_i & ~dual_buf_i;
    v1 = acc_out_rd_i & busy_i;
    v2 = acc_mode_wr_i & busy_i;
    v3 = acc_wo_rd_i;
    if (v0 | v1 | v2 | v3) begin
      m_acc = 1;
      m_type = v3 ? 3'd3 : v2 ? 3'd2 : v1 ? 3'd1 : 3'd0;
    end else if (sw_rst_i) begin
      m_acc = 0; m_type = 0;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    blk_done_i = 0; chk_done_i = 0; start_i = 0; sw_rst_i = 0; res_rd_i = 0;
    acc_in_wr_i = 0; acc_out_rd_i = 0; acc_mode_wr_i = 0; acc_wo_rd_i = 0;
  endtask

  task automatic check_all(input string req);
    check({req, " status"}, status_o, exp_status());
    check({req, " irq"}, {31'b0, irq_o}, {31'b0, exp_irq()});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected<=150000", cycles);
      done = 1;
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in reset
    check("R1 in reset", status_o, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 after release", status_o, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // R10: combinational write-ready
    in_ready_i = 1; #1;
    check("R10 wrdy high", status_o, 32'h10);
    in_ready_i = 0; #1;
    check("R10 wrdy low", status_o, 32'h0);
    @(negedge clk);

    // R3
    blk_done_i = 1; tick();
    check("R3 drdy set", status_o, 32'h1);
    res_rd_i = 1; tick();
    check("R3 cleared by read", status_o, 32'h0);
    blk_done_i = 1; tick();
    blk_done_i = 1; start_i = 1; tick();
    check("R3 set wins", status_o, 32'h1);
    start_i = 1; tick();
    check("R3 cleared by start", status_o, 32'h0);

    // R4/R5
    chk_done_i = 1; chk_code_i = 4'd5; tick();
    check("R5 match code", status_o, 32'h0051_0000);
    start_i = 1; tick();
    check("R4 cleared by start", status_o, 32'h0);
    chk_done_i = 1; chk_code_i = 4'd9; sw_rst_i = 1; tick();
    check("R4 set wins load", status_o, 32'h0091_0000);
    res_rd_i = 1; tick();
    check("R4 cleared by read", status_o, 32'h0);

    // R6 qualification
    acc_out_rd_i = 1; tick();
    check("R6 out read idle ignored", status_o, 32'h0);
    busy_i = 1; acc_out_rd_i = 1; tick();
    check("R6 code 1", status_o, 32'h0000_1100);
    acc_in_wr_i = 1; tick();
    check("R6 in write without dma ignored", status_o, 32'h0000_1100);
    dma_mode_i = 1; acc_in_wr_i = 1; tick();
    check("R6 code 0", status_o, 32'h0000_0100);
    acc_mode_wr_i = 1; tick();
    check("R6 code 2", status_o, 32'h0000_2100);
    // R7
    dual_buf_i = 1; acc_in_wr_i = 1; tick();
    check("R7 dual buffer ignores in write", status_o, 32'h0000_2100);
    dual_buf_i = 0; busy_i = 0; dma_mode_i = 0;
    acc_wo_rd_i = 1; tick();
    check("R6 code 3 idle", status_o, 32'h0000_3100);
    // R9
    start_i = 1; res_rd_i = 1; tick();
    check("R9 start/read keep flag", status_o, 32'h0000_3100);
    sw_rst_i = 1; tick();
    check("R9 sw reset clears", status_o, 32'h0);
    busy_i = 1; acc_out_rd_i = 1; sw_rst_i = 1; tick();
    check("R9 event beats sw reset", status_o, 32'h0000_1100);
    // R7 from clear flag
    sw_rst_i = 1; tick();
    dma_mode_i = 1; dual_buf_i = 1; acc_in_wr_i = 1; tick();
    check("R7 no flag from dual buffer", status_o, 32'h0);
    // R8
    dual_buf_i = 0;
    acc_in_wr_i = 1; acc_mode_wr_i = 1; acc_out_rd_i = 1; tick();
    check("R8 highest wins", status_o, 32'h0000_2100);
    acc_in_wr_i = 1; tick();
    check("R8 latest overwrites", status_o, 32'h0000_0100);
    busy_i = 0; dma_mode_i = 0;

    // R11 and R2
    blk_done_i = 1; chk_done_i = 1; chk_code_i = 4'hF; in_ready_i = 1; tick();
    check("R2 unused bits zero", status_o & ~32'h00F1_7111, 32'h0);
    check("R2 all fields", status_o, 32'h00F1_0111);
    irq_en_drdy_i = 1; #1;
    check("R11 irq drdy", {31'b0, irq_o}, 32'h1);
    irq_en_drdy_i = 0; irq_en_chk_i = 1; #1;
    check("R11 irq chk", {31'b0, irq_o}, 32'h1);
    irq_en_chk_i = 0; irq_en_acc_i = 1; #1;
    check("R11 irq acc", {31'b0, irq_o}, 32'h1);
    irq_en_acc_i = 0; #1;
    check("R11 irq masked", {31'b0, irq_o}, 32'h0);
    @(negedge clk);

    // sweeps over all 12-bit event/mode combinations, two orders
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 4096; i++) begin
        int v;
        v = (pass == 0) ? i : ((i * 2533 + 77) % 4096);
        blk_done_i = v[0]; chk_done_i = v[1]; start_i = v[2]; sw_rst_i = v[3];
        res_rd_i = v[4]; acc_in_wr_i = v[5]; acc_out_rd_i = v[6]; acc_mode_wr_i = v[7];
        acc_wo_rd_i = v[8]; busy_i = v[9]; dma_mode_i = v[10]; dual_buf_i = v[11];
        chk_code_i = 4'(v[3:0] ^ v[11:8]);
        in_ready_i = v[5] ^ v[9];
        tick();
        irq_en_drdy_i = v[0] ^ v[6]; irq_en_chk_i = v[1] ^ v[7]; irq_en_acc_i = v[2] ^ v[8];
        #1;
        check("R3 sweep drdy", {31'b0, status_o[0]}, {31'b0, m_drdy});
        check("R4 sweep chk/code", {27'b0, status_o[23:20], status_o[16]}, {27'b0, m_code, m_chk});
        check("R6 sweep type", {29'b0, status_o[14:12]}, {29'b0, m_type});
        check("R9 sweep flag", {31'b0, status_o[8]}, {31'b0, m_acc});
        check("R10 sweep wrdy", {31'b0, status_o[4]}, {31'b0, in_ready_i});
        check("R11 sweep irq", {31'b0, irq_o}, {31'b0, exp_irq()});
        check("R2 sweep layout", status_o, exp_status());
        @(negedge clk);
      end
    end

    done = 1;
    finish_run();
  end
endmodule